// File: doc/BRIEF.md
# AC-link Control and Wake Register

This block is the software-visible control point of an AC-link audio codec interface. It keeps five enable bits in a control word: release of the link reset, low-power forcing of the outgoing link lines, wake-up enable, warm reset and receive-slot choice. Every bit is set by writing a one to the set address and cleared by writing a one to a separate clear address. A zero in either write leaves the bit as it was, so independent software paths can change single bits without a read-modify-write.

The block also keeps one ready flag per codec. The receive-side frame logic sets a flag with a one-cycle pulse. Software clears all flags at once through a command bit in the set word, and reads the flags at a status address. The block gates the frame logic's SYNC and SDOUT lines on their way to the pins. It drives the active-low link reset and the warm-reset request. It raises a power-management interrupt while wake-up is enabled and any codec data input, after a two-flop synchronizer, is high.

The register bus is a plain word-addressed port: a write takes effect at the clock edge where the write strobe is high, and read data is a combinational function of the address.

Top module: `aclink_ctrl`

## Requirements
- R1: After reset every control bit and every ready flag is 0. So `acreset_n_o`, `warm_rst_o`, `mic_sel_o` and `wake_irq_o` are 0, and reads at addresses 0x0, 0x1 and 0x2 return 0.
- R2: A write to address 0x0 sets each control bit whose data bit is 1 and leaves the others unchanged. The bit positions are 0 link enable, 1 low-power, 2 wake enable, 3 warm reset and 4 microphone select. The control word reads back in bits 4:0 at both 0x0 and 0x1.
- R3: A write to address 0x1 clears each control bit whose data bit is 1 and leaves the others unchanged.
- R4: At addresses 0x0 and 0x1, read bits 7:5 are 0. Reads at any address above 0x2 return 0. Writes to those addresses change no control bit and no ready flag.
- R5: A pulse on `rdy_set_i[n]` sets ready flag n, which reads back at address 0x2 in bit n. Writing 1 to bit 5 at address 0x0 clears all ready flags. A set pulse in the same cycle as the clear wins for that codec.
- R6: While low-power is set, `sdout_o` is 0. `sync_o` is also 0 unless warm reset is set. While low-power is clear, both lines follow `sync_i` and `sdout_i`.
- R7: While warm reset is set, `warm_rst_o` is 1 and `sync_o` is 1, whatever low-power and `sync_i` are.
- R8: `wake_irq_o` equals wake enable AND the OR of the codec data inputs as seen two clock edges earlier. It stays high for as long as that condition holds.
- R9: `acreset_n_o` equals the link enable bit and `mic_sel_o` equals the microphone select bit. When microphone select is 0, slots 3 and 4 (PCM left/right) are received. When it is 1, slot 6 (microphone) is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, combinational from `addr_i` |
| rdy_set_i | input | NUM_CODEC | Per-codec ready set pulses from the frame receiver |
| sdin_i | input | NUM_CODEC | Codec serial data inputs (asynchronous) |
| sync_i | input | 1 | SYNC from the frame logic |
| sdout_i | input | 1 | SDOUT from the frame logic |
| sync_o | output | 1 | SYNC to the link pin |
| sdout_o | output | 1 | SDOUT to the link pin |
| acreset_n_o | output | 1 | Active-low link reset |
| warm_rst_o | output | 1 | Warm reset request |
| mic_sel_o | output | 1 | Receive slot select (0 PCM L/R, 1 microphone) |
| wake_irq_o | output | 1 | Power-management wake interrupt |

## Verification
The assertions assume that the address, strobe and data are stable at the sampling edge, and that `rdy_set_i` carries clean pulses. `sdin_i` may change at any time, because only its synchronized copy is observed. The stimulus changes every input on the falling clock edge, so each rising edge sees settled values. The stimulus also sweeps every pair of set and clear masks over the five control bits, every combination of low-power, warm reset and incoming line values, and every codec data pattern with wake enable both on and off.

// File: rtl/aclink_ctrl_pkg.sv
package aclink_ctrl_pkg;

    // Control word; the field order fixes the software bit positions
    // (link_en is bit 0, mic_sel is bit 4).
    typedef struct packed {
        logic mic_sel;
        logic warm_rst;
        logic wake_en;
        logic low_pwr;
        logic link_en;
    } ctl_bits_t;

    localparam int CTL_W       = $bits(ctl_bits_t);
    localparam int BIT_RDY_CLR = CTL_W;       // command bit above the control word

    typedef enum logic [1:0] {
        SEL_CTL_SET = 2'd0,
        SEL_CTL_CLR = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    localparam int ADDR_CTL_SET = 0;
    localparam int ADDR_CTL_CLR = 1;
    localparam int ADDR_STATUS  = 2;

    function automatic reg_sel_e decode_addr(input int unsigned a);
        case (a)
            ADDR_CTL_SET: return SEL_CTL_SET;
            ADDR_CTL_CLR: return SEL_CTL_CLR;
            ADDR_STATUS:  return SEL_STATUS;
            default:      return SEL_NONE;
        endcase
    endfunction

    // Pin-side gating: warm reset beats low-power on SYNC.
    function automatic logic gate_sync(input ctl_bits_t c, input logic s);
        if (c.warm_rst)     return 1'b1;
        else if (c.low_pwr) return 1'b0;
        else                return s;
    endfunction

    function automatic logic gate_sdout(input ctl_bits_t c, input logic d);
        return c.low_pwr ? 1'b0 : d;
    endfunction

endpackage

// File: rtl/aclink_ctl_bank.sv
module aclink_ctl_bank
    import aclink_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_bits_t set_mask,
    input  ctl_bits_t clr_mask,
    output ctl_bits_t ctl_q
);
    ctl_bits_t ctl_next;

    // A clear wins over a set of the same bit.
    always_comb begin
        ctl_next = ctl_bits_t'((ctl_q | set_mask) & ~clr_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_next;
    end
endmodule

// File: rtl/aclink_ready_flags.sv
module aclink_ready_flags #(
    parameter int NUM_CODEC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CODEC-1:0] set_pulse,
    input  logic                 clr_all,
    output logic [NUM_CODEC-1:0] rdy_q
);
    for (genvar n = 0; n < NUM_CODEC; n++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)               rdy_q[n] <= 1'b0;
            else if (set_pulse[n]) rdy_q[n] <= 1'b1;
            else if (clr_all)      rdy_q[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/aclink_wake_detect.sv
module aclink_wake_detect #(
    parameter int NUM_CODEC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CODEC-1:0] sdin,
    input  logic                 wake_en,
    output logic                 wake_irq
);
    logic [NUM_CODEC-1:0] stage_q [SYNC_STAGES];
    logic [NUM_CODEC-1:0] sdin_sync;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= sdin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sdin_sync = stage_q[SYNC_STAGES-1];
    assign wake_irq  = wake_en & (|sdin_sync);
endmodule

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
    import aclink_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int NUM_CODEC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic [NUM_CODEC-1:0] rdy_set_i,
    input  logic [NUM_CODEC-1:0] sdin_i,
    input  logic                 sync_i,
    input  logic                 sdout_i,
    output logic                 sync_o,
    output logic                 sdout_o,
    output logic                 acreset_n_o,
    output logic                 warm_rst_o,
    output logic                 mic_sel_o,
    output logic                 wake_irq_o
);
    localparam int HI_W = DATA_W - BIT_RDY_CLR - 1;

    reg_sel_e  sel;
    ctl_bits_t wr_ctl;
    ctl_bits_t set_mask;
    ctl_bits_t clr_mask;
    ctl_bits_t ctl_q;
    logic      rdy_clr;
    logic [NUM_CODEC-1:0] rdy_q;
    logic [HI_W-1:0] unused_wdata_hi;

    assign sel             = decode_addr(int'(addr_i));
    assign wr_ctl          = ctl_bits_t'(wr_data_i[CTL_W-1:0]);
    assign unused_wdata_hi = wr_data_i[DATA_W-1:BIT_RDY_CLR+1];

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        rdy_clr  = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_CTL_SET: begin
                    set_mask = wr_ctl;
                    rdy_clr  = wr_data_i[BIT_RDY_CLR];
                end
                SEL_CTL_CLR: clr_mask = wr_ctl;
                default: ;
            endcase
        end
    end

    aclink_ctl_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .ctl_q    (ctl_q)
    );

    aclink_ready_flags #(.NUM_CODEC(NUM_CODEC)) u_ready (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (rdy_set_i),
        .clr_all   (rdy_clr),
        .rdy_q     (rdy_q)
    );

    aclink_wake_detect #(.NUM_CODEC(NUM_CODEC), .SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .sdin     (sdin_i),
        .wake_en  (ctl_q.wake_en),
        .wake_irq (wake_irq_o)
    );

    // Read mux
    always_comb begin
        rd_data_o = '0;
        unique case (sel)
            SEL_CTL_SET, SEL_CTL_CLR: rd_data_o[CTL_W-1:0] = ctl_q;
            SEL_STATUS:               rd_data_o[NUM_CODEC-1:0] = rdy_q;
            default: ;
        endcase
    end

    // Link-side outputs
    assign sync_o      = gate_sync(ctl_q, sync_i);
    assign sdout_o     = gate_sdout(ctl_q, sdout_i);
    assign acreset_n_o = ctl_q.link_en;
    assign warm_rst_o  = ctl_q.warm_rst;
    assign mic_sel_o   = ctl_q.mic_sel;
endmodule

// File: rtl/aclink_ctrl_chk.sv
module aclink_ctrl_chk
    import aclink_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int NUM_CODEC = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 wr_en_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic [DATA_W-1:0]    rd_data_o,
    input logic [NUM_CODEC-1:0] rdy_set_i,
    input logic                 sync_o,
    input logic                 sdout_o,
    input logic                 acreset_n_o,
    input logic                 warm_rst_o,
    input logic                 wake_irq_o,
    input ctl_bits_t            ctl_q,
    input logic [NUM_CODEC-1:0] rdy_q
);
    logic wr_set, wr_clr;
    assign wr_set = wr_en_i && (addr_i == ADDR_W'(ADDR_CTL_SET));
    assign wr_clr = wr_en_i && (addr_i == ADDR_W'(ADDR_CTL_CLR));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (ctl_q == '0 && rdy_q == '0)); // R1

    AST_SET_LINK: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wr_data_i[0]) |=> acreset_n_o); // R2

    AST_ZERO_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wr_data_i[CTL_W-1:0] == '0) |=> $stable(ctl_q)); // R2

    AST_CLR_LINK: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wr_data_i[0]) |=> !acreset_n_o); // R3

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr_i <= ADDR_W'(ADDR_CTL_CLR)) |-> (rd_data_o[DATA_W-1:CTL_W] == '0)); // R4

    AST_READY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wr_data_i[BIT_RDY_CLR] && rdy_set_i == '0) |=> (rdy_q == '0)); // R5

    AST_LOWPWR_SDOUT: assert property (@(posedge clk) disable iff (rst)
        ctl_q.low_pwr |-> !sdout_o); // R6

    AST_WARM_SYNC: assert property (@(posedge clk) disable iff (rst)
        warm_rst_o |-> sync_o); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        wake_irq_o |-> ctl_q.wake_en); // R8
endmodule

bind aclink_ctrl aclink_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CODEC(NUM_CODEC)
) u_chk (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rdy_set_i(rdy_set_i),
    .sync_o(sync_o), .sdout_o(sdout_o), .acreset_n_o(acreset_n_o),
    .warm_rst_o(warm_rst_o), .wake_irq_o(wake_irq_o),
    .ctl_q(ctl_q), .rdy_q(rdy_q)
);

// File: tb/aclink_ctrl_test.sv
`timescale 1ns/100ps
module aclink_ctrl_test;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NC     = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NC-1:0]     rdy_set = '0;
    logic [NC-1:0]     sdin = '0;
    logic              sync_in = 1'b0, sdout_in = 1'b0;
    logic              sync_o, sdout_o, acreset_n, warm_rst, mic_sel, wake_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    aclink_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CODEC(NC)) uut (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .rdy_set_i(rdy_set),
        .sdin_i(sdin), .sync_i(sync_in), .sdout_i(sdout_in),
        .sync_o(sync_o), .sdout_o(sdout_o), .acreset_n_o(acreset_n),
        .warm_rst_o(warm_rst), .mic_sel_o(mic_sel), .wake_irq_o(wake_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = ADDR_W'(a); wr_data = DATA_W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wr_data = '0;
    endtask

    task automatic rd(input int a, output int d);
        addr = ADDR_W'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic check_outputs(input string req, input int ctl);
        check({req, " acreset_n"}, int'(acreset_n), ctl & 1);
        check({req, " warm_rst"},  int'(warm_rst), (ctl >> 3) & 1);
        check({req, " mic_sel"},   int'(mic_sel), (ctl >> 4) & 1);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 3; a++) begin
            rd(a, d); check("R1 read", d, 0);
        end
        check_outputs("R1", 0);
        check("R1 irq", int'(wake_irq), 0);

        // R2/R3/R9: sweep set mask v then w, then clear mask w
        for (int v = 0; v < 32; v++) begin
            for (int w = 0; w < 32; w++) begin
                wr(1, 8'h1F);
                wr(0, v | 8'hC0);          // upper bits ignored
                wr(0, w);
                rd(0, d); check("R2 set or", d, v | w);
                rd(1, d); check("R2 read alias", d, v | w);
                check_outputs("R9", v | w);
                wr(1, w | 8'hE0);
                rd(0, d); check("R3 clear", d, (v | w) & ~w);
                wr(1, 0);
                rd(0, d); check("R3 zero clear no effect", d, (v | w) & ~w);
                check("R4 reserved", d & 8'hE0, 0);
            end
        end

        // R4: unmapped addresses
        wr(1, 8'h1F);
        wr(0, 8'h05);
        rdy_set = 2'b10;
        @(negedge clk); rdy_set = '0;
        for (int a = 3; a < 16; a++) begin
            wr(a, 8'hFF);
            rd(a, d); check("R4 unmapped read", d, 0);
            rd(0, d); check("R4 unmapped write ctl", d, 8'h05);
            rd(2, d); check("R4 unmapped write rdy", d, 2'b10);
        end

        // R5: ready flags
        wr(0, 8'h20);
        rd(2, d); check("R5 clear all", d, 0);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); rdy_set = NC'(p);
            @(negedge clk); rdy_set = '0;
            rd(2, d); check("R5 set pulse", d, p);
            wr(0, 8'h00);
            rd(2, d); check("R5 clear bit 0 no effect", d, p);
            @(negedge clk);
            addr = '0; wr_data = 8'h20; wr_en = 1'b1; rdy_set = 2'b01;
            @(negedge clk);
            wr_en = 1'b0; rdy_set = '0;
            rd(2, d); check("R5 set beats clear", d, 1);
            wr(0, 8'h20);
        end

        // R6/R7: pin gating sweep
        for (int c = 0; c < 16; c++) begin
            int lp, wm, si, di;
            lp = c & 1; wm = (c >> 1) & 1; si = (c >> 2) & 1; di = (c >> 3) & 1;
            wr(1, 8'h1F);
            wr(0, (lp << 1) | (wm << 3));
            @(negedge clk); sync_in = si[0]; sdout_in = di[0];
            #1;
            check("R6 sdout", int'(sdout_o), lp ? 0 : di);
            check("R7 sync", int'(sync_o), wm ? 1 : (lp ? 0 : si));
            check("R7 warm_rst", int'(warm_rst), wm);
        end
        sync_in = 1'b0; sdout_in = 1'b0;

        // R8: wake interrupt, latency and level
        for (int c = 0; c < 8; c++) begin
            int en, pat;
            en = c & 1; pat = (c >> 1) & 3;
            wr(1, 8'h1F);
            sdin = '0;
            repeat (3) @(negedge clk);
            wr(0, en << 2);
            @(negedge clk); sdin = NC'(pat);
            @(negedge clk);
            check("R8 one edge, not yet", int'(wake_irq), 0);
            @(negedge clk);
            check("R8 after sync", int'(wake_irq), (en != 0 && pat != 0) ? 1 : 0);
            repeat (4) @(negedge clk);
            check("R8 holds", int'(wake_irq), (en != 0 && pat != 0) ? 1 : 0);
        end
        sdin = '0;
        repeat (3) @(negedge clk);
        check("R8 drop", int'(wake_irq), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule